// File: doc/BRIEF.md
# Platform Power Rail Sequencer

This block is a clocked state machine that raises and lowers a platform's supply rails in a fixed order. It steps through four settled power levels: off, standby, suspend and run. It drives one enable per rail group and the host handshake outputs, which are an active-low host reset, a sustain power-good, a system power-ok and a host power-ok. Before each step it waits for digital power-good inputs or for millivolt readings from an external rail monitor. It also inserts fixed delays between steps.

A request input brings the platform from off to standby. From there, two host sleep inputs, both active low, call for suspend and run. Teardown reverses the bring-up one output per clock. The sequencer leaves a gap of more than 400 ns before it removes the I/O rail, and another before the standby rails go down. Three things abort a power state: a wait that runs out of time, a forced shutdown, or the request going low. Each abort runs the whole teardown and ends in off. The block leaves off only on a fresh rising edge of the request. All control and power-good inputs pass through two-flop synchronizers. The millivolt readings are assumed to be synchronous to the clock.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is applied and after it is released, every rail enable and every handshake output is low, including `host_rst_n`. `pstate` reads 0. The `pstate` encoding is 0 for off, 1 for standby, 2 for suspend and 3 for run.
- R2: A rising edge of `pwr_req` raises `en_5v`. The block raises `en_3v3` only after `pg_5v` is high. It raises `en_1v8` only once `mv_3v3` is at least 3000; a reading of 2999 keeps it waiting. It reaches standby (`pstate`=1) only when `pg_1v8` and `pg_1v05` are both high.
- R3: `host_rst_n` rises no earlier than RST_DLY_US after both `pg_1v8` and `pg_1v05` are seen high. At that moment all three standby enables are high.
- R4: In standby, a high `slp_deep_n` starts the move to suspend. The block enters suspend (`pstate`=2) only when `pg_dram25` and `pg_dram12` are both high. In suspend, a low `slp_deep_n` returns the block to standby, and no rail enable or `host_rst_n` changes.
- R5: In suspend, a high `slp_susp_n` runs the run bring-up:
  - it waits for `mv_sus` to reach at least 1000 (999 keeps it waiting), then raises `en_run`;
  - at least STEP_DLY_US later it raises `en_io`;
  - after `pg_io` it raises `sus_pg`, then `en_core`;
  - at least STEP_DLY_US later it raises `sys_pwrok`;
  - after `core_ready`, and at least STEP_DLY_US later, it raises `host_pwrok` and enters run (`pstate`=3).
- R6: In run, a low `slp_susp_n` drops these outputs on strictly later clocks in this order: `sus_pg`, `host_pwrok`, `sys_pwrok`, `en_core`, `en_run`. More than GAP_NS later it drops `en_io`. It ends in suspend, and the standby rails stay on.
- R7: Standby teardown first drives `host_rst_n` low. More than GAP_NS later it drops `en_1v8`, then `en_3v3`, then `en_5v`, each on a strictly later clock. It ends in off.
- R8: When a power-good or millivolt wait lasts TIMEOUT_CYC cycles, the block runs the R6 drop sequence and then the R7 teardown, and it ends in off. It leaves off only on a new rising edge of `pwr_req`.
- R9: `force_off` high, or `pwr_req` low, in any powered state runs the full R6 sequence and then the R7 teardown, ending in off.
- R10: Each wait starts its own timeout window. Two successive waits that each finish within TIMEOUT_CYC cycles do not cause a timeout, even when their total is longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Platform power request; a rising edge starts bring-up |
| force_off | input | 1 | Forced shutdown request |
| slp_deep_n | input | 1 | Host deepest sleep signal, active low |
| slp_susp_n | input | 1 | Host suspend sleep signal, active low |
| pg_5v | input | 1 | 5 V rail power-good |
| pg_1v8 | input | 1 | 1.8 V rail power-good |
| pg_1v05 | input | 1 | 1.05 V standby rail power-good |
| pg_dram25 | input | 1 | 2.5 V memory rail power-good |
| pg_dram12 | input | 1 | 1.2 V memory rail power-good |
| pg_io | input | 1 | I/O rail power-good |
| core_ready | input | 1 | Core regulator ready |
| mv_3v3 | input | MV_W | 3.3 V rail reading in mV |
| mv_sus | input | MV_W | Sustain rail reading in mV |
| en_5v | output | 1 | 5 V rail enable |
| en_3v3 | output | 1 | 3.3 V rails enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| en_run | output | 1 | Run rail switches enable |
| en_io | output | 1 | I/O rail enable |
| en_core | output | 1 | Core regulator enable |
| sus_pg | output | 1 | Sustain power-good to host |
| sys_pwrok | output | 1 | System power-ok to host |
| host_pwrok | output | 1 | Host power-ok |
| host_rst_n | output | 1 | Host reset, active low |
| pstate | output | 2 | Settled power level: 0 off, 1 standby, 2 suspend, 3 run |

## Verification
Bring-up is tested with each power-good held back on its own, to show that the block is waiting on that exact input. The millivolt readings are tested at one below and exactly at their thresholds, which separates a correct compare from an off-by-one. Teardown is tested from three triggers: sleep entry from run, forced shutdown, and request loss from standby. The stamps of the falling edges expose any reordering, any drops on the same clock, and any shortened gap. Timeouts are tested with a stuck 5 V good and with stuck memory goods. A separate case answers two successive waits just inside the window, to tell a per-wait timer from a shared one.

// File: rtl/railseq_pkg.sv
// Package: shared state, output bundle and encodings for the rail sequencer.
// Assumes nothing beyond SystemVerilog-2017 packed types.
package railseq_pkg;

    // Bit positions of the synchronized input bundle.
    localparam int SI_PG_5V    = 0;
    localparam int SI_PG_1V8   = 1;
    localparam int SI_PG_1V05  = 2;
    localparam int SI_PG_D25   = 3;
    localparam int SI_PG_D12   = 4;
    localparam int SI_PG_IO    = 5;
    localparam int SI_CORE_RDY = 6;
    localparam int SI_SLP_DEEP = 7;
    localparam int SI_SLP_SUSP = 8;
    localparam int SI_REQ      = 9;
    localparam int SI_KILL     = 10;
    localparam int SI_COUNT    = 11;

    // Settled power level codes seen on pstate.
    localparam logic [1:0] PST_OFF  = 2'd0;
    localparam logic [1:0] PST_STBY = 2'd1;
    localparam logic [1:0] PST_SUSP = 2'd2;
    localparam logic [1:0] PST_RUN  = 2'd3;

    typedef enum logic [4:0] {
        S_OFF, S_UP_5V, S_UP_3V3, S_UP_1V8, S_RST_DLY,
        S_STBY, S_UP_DRAM, S_SUSP,
        S_UP_SUS, S_RUN_DLY, S_UP_IO, S_CORE_EN, S_CORE_DLY, S_UP_RDY, S_OK_DLY,
        S_RUN,
        S_DN_SUSPG, S_DN_HOSTOK, S_DN_SYSOK, S_DN_CORE, S_DN_RUN, S_DN_IOGAP,
        S_DN_RST, S_DN_RAILGAP, S_DN_3V3, S_DN_5V
    } seq_state_t;

    // Registered output bundle.
    typedef struct packed {
        logic en_5v;
        logic en_3v3;
        logic en_1v8;
        logic en_run;
        logic en_io;
        logic en_core;
        logic sus_pg;
        logic sys_pwrok;
        logic host_pwrok;
        logic host_rst_n;
    } rail_out_t;

endpackage

// File: rtl/railseq_sync.sv
// Module: two-flop synchronizer bank for asynchronous status inputs.
// Assumes each bit is independent (no multi-bit coherence needed).
module railseq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        // Two-stage capture of one input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/railseq_delay.sv
// Module: shared down-counter for all fixed delays and gaps.
// Assumes the owner loads a non-zero count and waits for zero.
module railseq_delay #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);
    logic [WIDTH-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/railseq_wdog.sv
// Module: per-wait timeout counter; restarts whenever the owner changes state.
// Assumes LIMIT >= 2.
module railseq_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count cycles spent in one armed wait, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !arm)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = arm && (cnt == LAST);
endmodule

// File: rtl/rail_sequencer.sv
// Module: platform power rail sequencer (top).
// Walks off -> standby -> suspend -> run in a fixed rail order, waits on
// synchronized power-good inputs and millivolt readings, inserts fixed delays
// from one shared counter, and tears down in reverse with enforced gaps.
// Assumes mv_* are synchronous to clk; all other inputs may be asynchronous.
module rail_sequencer #(
    parameter int CLK_KHZ     = 24000,
    parameter int RST_DLY_US  = 10000,
    parameter int STEP_DLY_US = 2000,
    parameter int GAP_NS      = 400,
    parameter int TIMEOUT_CYC = CLK_KHZ * 1000,
    parameter int MV_W        = 13,
    parameter int TH_3V3_MV   = 3000,
    parameter int TH_SUS_MV   = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_req,
    input  logic            force_off,
    input  logic            slp_deep_n,
    input  logic            slp_susp_n,
    input  logic            pg_5v,
    input  logic            pg_1v8,
    input  logic            pg_1v05,
    input  logic            pg_dram25,
    input  logic            pg_dram12,
    input  logic            pg_io,
    input  logic            core_ready,
    input  logic [MV_W-1:0] mv_3v3,
    input  logic [MV_W-1:0] mv_sus,
    output logic            en_5v,
    output logic            en_3v3,
    output logic            en_1v8,
    output logic            en_run,
    output logic            en_io,
    output logic            en_core,
    output logic            sus_pg,
    output logic            sys_pwrok,
    output logic            host_pwrok,
    output logic            host_rst_n,
    output logic [1:0]      pstate
);
    import railseq_pkg::*;

    localparam int RST_CYC  = (RST_DLY_US * CLK_KHZ) / 1000;
    localparam int STEP_CYC = (STEP_DLY_US * CLK_KHZ) / 1000;
    localparam int GAP_CYC  = (GAP_NS * CLK_KHZ) / 1000000 + 1;
    localparam int DLY_MAX  = (RST_CYC > STEP_CYC) ?
                              ((RST_CYC > GAP_CYC) ? RST_CYC : GAP_CYC) :
                              ((STEP_CYC > GAP_CYC) ? STEP_CYC : GAP_CYC);
    localparam int DLY_W    = $clog2(DLY_MAX + 1);
    localparam logic [DLY_W-1:0] RST_LD  = DLY_W'(RST_CYC);
    localparam logic [DLY_W-1:0] STEP_LD = DLY_W'(STEP_CYC);
    localparam logic [DLY_W-1:0] GAP_LD  = DLY_W'(GAP_CYC);
    localparam logic [MV_W-1:0]  TH_3V3  = MV_W'(TH_3V3_MV);
    localparam logic [MV_W-1:0]  TH_SUS  = MV_W'(TH_SUS_MV);

    // ---------------- input synchronization ----------------
    logic [SI_COUNT-1:0] raw_in, sy;

    assign raw_in = {force_off, pwr_req, slp_susp_n, slp_deep_n, core_ready,
                     pg_io, pg_dram12, pg_dram25, pg_1v05, pg_1v8, pg_5v};

    railseq_sync #(.WIDTH(SI_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sy)
    );

    // ---------------- state and helpers ----------------
    seq_state_t       state_q, state_n;
    rail_out_t        outs_q, outs_n;
    logic             to_off_q, to_off_n;
    logic             req_prev;
    logic             tmr_load, tmr_zero;
    logic [DLY_W-1:0] tmr_val;
    logic             wait_st, wd_clr, wd_exp;
    logic             req_rise, kill, powered, run_side;

    assign req_rise = sy[SI_REQ] && !req_prev;
    assign kill     = sy[SI_KILL] || !sy[SI_REQ];
    assign powered  = !(state_q inside {S_OFF, S_DN_SUSPG, S_DN_HOSTOK,
                        S_DN_SYSOK, S_DN_CORE, S_DN_RUN, S_DN_IOGAP, S_DN_RST,
                        S_DN_RAILGAP, S_DN_3V3, S_DN_5V});
    assign run_side = state_q inside {S_UP_SUS, S_RUN_DLY, S_UP_IO, S_CORE_EN,
                        S_CORE_DLY, S_UP_RDY, S_OK_DLY, S_RUN};

    railseq_delay #(.WIDTH(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    railseq_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .clear(wd_clr), .arm(wait_st),
        .expired(wd_exp)
    );

    // Next-state, next-output and timer control for the sequence.
    always_comb begin
        state_n  = state_q;
        outs_n   = outs_q;
        to_off_n = to_off_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        wait_st  = 1'b0;
        case (state_q)
            S_OFF: if (req_rise && !sy[SI_KILL]) begin
                outs_n.en_5v = 1'b1;
                state_n      = S_UP_5V;
            end
            S_UP_5V: begin
                wait_st = 1'b1;
                if (sy[SI_PG_5V]) begin
                    outs_n.en_3v3 = 1'b1;
                    state_n       = S_UP_3V3;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_UP_3V3: begin
                wait_st = 1'b1;
                if (mv_3v3 >= TH_3V3) begin
                    outs_n.en_1v8 = 1'b1;
                    state_n       = S_UP_1V8;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_UP_1V8: begin
                wait_st = 1'b1;
                if (sy[SI_PG_1V8] && sy[SI_PG_1V05]) begin
                    tmr_load = 1'b1; tmr_val = RST_LD;
                    state_n  = S_RST_DLY;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_RST_DLY: if (tmr_zero) begin
                outs_n.host_rst_n = 1'b1;
                state_n           = S_STBY;
            end
            S_STBY: if (sy[SI_SLP_DEEP]) state_n = S_UP_DRAM;
            S_UP_DRAM: begin
                wait_st = 1'b1;
                if (!sy[SI_SLP_DEEP])
                    state_n = S_STBY;
                else if (sy[SI_PG_D25] && sy[SI_PG_D12])
                    state_n = S_SUSP;
                else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_SUSP: begin
                if (!sy[SI_SLP_DEEP])     state_n = S_STBY;
                else if (sy[SI_SLP_SUSP]) state_n = S_UP_SUS;
            end
            S_UP_SUS: begin
                wait_st = 1'b1;
                if (mv_sus >= TH_SUS) begin
                    outs_n.en_run = 1'b1;
                    tmr_load = 1'b1; tmr_val = STEP_LD;
                    state_n  = S_RUN_DLY;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_RUN_DLY: if (tmr_zero) begin
                outs_n.en_io = 1'b1;
                state_n      = S_UP_IO;
            end
            S_UP_IO: begin
                wait_st = 1'b1;
                if (sy[SI_PG_IO]) begin
                    outs_n.sus_pg = 1'b1;
                    state_n       = S_CORE_EN;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_CORE_EN: begin
                outs_n.en_core = 1'b1;
                tmr_load = 1'b1; tmr_val = STEP_LD;
                state_n  = S_CORE_DLY;
            end
            S_CORE_DLY: if (tmr_zero) begin
                outs_n.sys_pwrok = 1'b1;
                state_n          = S_UP_RDY;
            end
            S_UP_RDY: begin
                wait_st = 1'b1;
                if (sy[SI_CORE_RDY]) begin
                    tmr_load = 1'b1; tmr_val = STEP_LD;
                    state_n  = S_OK_DLY;
                end else if (wd_exp) begin
                    state_n = S_DN_SUSPG; to_off_n = 1'b1;
                end
            end
            S_OK_DLY: if (tmr_zero) begin
                outs_n.host_pwrok = 1'b1;
                state_n           = S_RUN;
            end
            S_RUN: ;
            S_DN_SUSPG:  begin outs_n.sus_pg     = 1'b0; state_n = S_DN_HOSTOK; end
            S_DN_HOSTOK: begin outs_n.host_pwrok = 1'b0; state_n = S_DN_SYSOK;  end
            S_DN_SYSOK:  begin outs_n.sys_pwrok  = 1'b0; state_n = S_DN_CORE;   end
            S_DN_CORE:   begin outs_n.en_core    = 1'b0; state_n = S_DN_RUN;    end
            S_DN_RUN: begin
                outs_n.en_run = 1'b0;
                tmr_load = 1'b1; tmr_val = GAP_LD;
                state_n  = S_DN_IOGAP;
            end
            S_DN_IOGAP: if (tmr_zero) begin
                outs_n.en_io = 1'b0;
                state_n      = to_off_q ? S_DN_RST : S_SUSP;
            end
            S_DN_RST: begin
                outs_n.host_rst_n = 1'b0;
                tmr_load = 1'b1; tmr_val = GAP_LD;
                state_n  = S_DN_RAILGAP;
            end
            S_DN_RAILGAP: if (tmr_zero) begin
                outs_n.en_1v8 = 1'b0;
                state_n       = S_DN_3V3;
            end
            S_DN_3V3: begin outs_n.en_3v3 = 1'b0; state_n = S_DN_5V; end
            S_DN_5V:  begin outs_n.en_5v  = 1'b0; state_n = S_OFF;   end
            default: state_n = S_OFF;
        endcase

        // Leaving run-side states when the host re-enters suspend sleep.
        if (run_side && !sy[SI_SLP_SUSP] && state_n != S_DN_SUSPG) begin
            state_n  = S_DN_SUSPG;
            outs_n   = outs_q;
            tmr_load = 1'b0;
            to_off_n = 1'b0;
        end
        // Forced shutdown or request loss overrides everything.
        if (powered && kill) begin
            state_n  = S_DN_SUSPG;
            outs_n   = outs_q;
            tmr_load = 1'b0;
            to_off_n = 1'b1;
        end
    end

    assign wd_clr = (state_n != state_q);

    // Sequencer registers: state, outputs, teardown target, request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_OFF;
            outs_q   <= '0;
            to_off_q <= 1'b0;
            req_prev <= 1'b0;
        end else begin
            state_q  <= state_n;
            outs_q   <= outs_n;
            to_off_q <= to_off_n;
            req_prev <= sy[SI_REQ];
        end
    end

    // Settled power level, updated on arrival at a settled state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pstate <= PST_OFF;
        else begin
            case (state_n)
                S_OFF:   pstate <= PST_OFF;
                S_STBY:  pstate <= PST_STBY;
                S_SUSP:  pstate <= PST_SUSP;
                S_RUN:   pstate <= PST_RUN;
                default: ;
            endcase
        end
    end

    assign en_5v      = outs_q.en_5v;
    assign en_3v3     = outs_q.en_3v3;
    assign en_1v8     = outs_q.en_1v8;
    assign en_run     = outs_q.en_run;
    assign en_io      = outs_q.en_io;
    assign en_core    = outs_q.en_core;
    assign sus_pg     = outs_q.sus_pg;
    assign sys_pwrok  = outs_q.sys_pwrok;
    assign host_pwrok = outs_q.host_pwrok;
    assign host_rst_n = outs_q.host_rst_n;

    // ---------------- ordering assertions ----------------
    assert_3v3_after_5v_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_3v3) |-> en_5v);
    assert_rst_release_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rst_n) |-> (en_5v && en_3v3 && en_1v8));
    assert_io_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_io) |-> en_run);
    assert_pwrok_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pwrok) |-> (sys_pwrok && sus_pg && en_core && en_io));
    assert_io_drop_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_io) |-> (!en_run && !sus_pg && !host_pwrok && !en_core));
    assert_5v_drop_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_5v) |-> (!en_3v3 && !en_1v8 && !host_rst_n && !en_io));

endmodule

// File: tb/sim_rail_sequencer.sv
`timescale 1ns/1ps
module sim_rail_sequencer;
    localparam int CLK_PERIOD = 100;
    localparam int CLK_KHZ    = 10000;
    localparam int RST_US     = 20;
    localparam int STEP_US    = 5;
    localparam int GAP_NS     = 400;
    localparam int TO_CYC     = 300;
    localparam int RST_C      = RST_US * CLK_KHZ / 1000;
    localparam int STEP_C     = STEP_US * CLK_KHZ / 1000;
    localparam int GAP_C      = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwr_req = 0, force_off = 0, slp_deep_n = 0, slp_susp_n = 0;
    logic pg_5v = 0, pg_1v8 = 0, pg_1v05 = 0, pg_dram25 = 0, pg_dram12 = 0;
    logic pg_io = 0, core_ready = 0;
    logic [12:0] mv_3v3 = '0, mv_sus = '0;
    logic en_5v, en_3v3, en_1v8, en_run, en_io, en_core;
    logic sus_pg, sys_pwrok, host_pwrok, host_rst_n;
    logic [1:0] pstate;
    logic [9:0] sigs, prev;

    int cyc = 0, checks = 0, fails = 0;
    int rise_at[10], fall_at[10];

    localparam int I5V = 0, I3V3 = 1, I1V8 = 2, IRUN = 3, IIO = 4, ICORE = 5;
    localparam int ISPG = 6, ISYS = 7, IHOK = 8, IRST = 9;

    rail_sequencer #(.CLK_KHZ(CLK_KHZ), .RST_DLY_US(RST_US), .STEP_DLY_US(STEP_US),
                     .GAP_NS(GAP_NS), .TIMEOUT_CYC(TO_CYC), .MV_W(13)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .force_off(force_off),
        .slp_deep_n(slp_deep_n), .slp_susp_n(slp_susp_n), .pg_5v(pg_5v),
        .pg_1v8(pg_1v8), .pg_1v05(pg_1v05), .pg_dram25(pg_dram25),
        .pg_dram12(pg_dram12), .pg_io(pg_io), .core_ready(core_ready),
        .mv_3v3(mv_3v3), .mv_sus(mv_sus), .en_5v(en_5v), .en_3v3(en_3v3),
        .en_1v8(en_1v8), .en_run(en_run), .en_io(en_io), .en_core(en_core),
        .sus_pg(sus_pg), .sys_pwrok(sys_pwrok), .host_pwrok(host_pwrok),
        .host_rst_n(host_rst_n), .pstate(pstate));

    assign sigs = {host_rst_n, host_pwrok, sys_pwrok, sus_pg, en_core, en_io,
                   en_run, en_1v8, en_3v3, en_5v};

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge stamp monitor, sampled shortly after each rising edge.
    initial begin
        prev = '0;
        for (int i = 0; i < 10; i++) begin rise_at[i] = -1; fall_at[i] = -1; end
        forever begin
            @(posedge clk); #(CLK_PERIOD/8);
            for (int i = 0; i < 10; i++) begin
                if (sigs[i] && !prev[i]) rise_at[i] = cyc;
                if (!sigs[i] && prev[i]) fall_at[i] = cyc;
            end
            prev = sigs;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #(CLK_PERIOD/4); end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stamps();
        for (int i = 0; i < 10; i++) begin rise_at[i] = -1; fall_at[i] = -1; end
    endtask

    task automatic wait_sig(input int idx, input bit v, input int maxc, input string tag);
        for (int i = 0; i < maxc && sigs[idx] !== v; i++) tick();
        chk(sigs[idx] === v, tag, int'(sigs[idx]), int'(v));
    endtask

    task automatic wait_pst(input logic [1:0] v, input int maxc, input string tag);
        for (int i = 0; i < maxc && pstate !== v; i++) tick();
        chk(pstate === v, tag, int'(pstate), int'(v));
    endtask

    task automatic t_reset();
        tick(3);
        chk(sigs === 10'd0, "R1 outputs low in reset", int'(sigs), 0);
        rst_n = 1'b1;
        tick(5);
        chk(sigs === 10'd0 && pstate === 2'd0, "R1 idle after reset",
            int'({pstate, sigs}), 0);
    endtask

    task automatic t_standby_up();
        int t0;
        clear_stamps();
        pwr_req = 1; 
        wait_sig(I5V, 1, 20, "R2 en_5v rises on request");
        tick(10);
        chk(!en_3v3, "R2 3v3 held until pg_5v", int'(en_3v3), 0);
        pg_5v = 1;
        wait_sig(I3V3, 1, 20, "R2 en_3v3 after pg_5v");
        mv_3v3 = 13'd2999; tick(20);
        chk(!en_1v8, "R2 1v8 held at 2999 mV", int'(en_1v8), 0);
        mv_3v3 = 13'd3000;
        wait_sig(I1V8, 1, 20, "R2 en_1v8 at 3000 mV");
        pg_1v8 = 1; tick(20);
        chk(pstate == 2'd0 && !host_rst_n, "R2 standby needs pg_1v05",
            int'(pstate), 0);
        pg_1v05 = 1; t0 = cyc;
        wait_sig(IRST, 1, RST_C + 20, "R3 reset release");
        chk(rise_at[IRST] - t0 >= RST_C && rise_at[IRST] - t0 <= RST_C + 8,
            "R3 reset delay", rise_at[IRST] - t0, RST_C);
        tick(2);
        chk(pstate == 2'd1, "R2 standby reached", int'(pstate), 1);
        chk(rise_at[I5V] < rise_at[I3V3] && rise_at[I3V3] < rise_at[I1V8],
            "R2 rise order", rise_at[I3V3], rise_at[I5V] + 1);
    endtask

    task automatic t_suspend();
        slp_deep_n = 1; pg_dram25 = 1; tick(20);
        chk(pstate == 2'd1, "R4 suspend needs pg_dram12", int'(pstate), 1);
        pg_dram12 = 1;
        wait_pst(2'd2, 20, "R4 suspend reached");
        clear_stamps();
        slp_deep_n = 0;
        wait_pst(2'd1, 20, "R4 back to standby");
        chk(sigs === 10'b10_0000_0111 && rise_at[IRST] < 0 && fall_at[IRST] < 0,
            "R4 outputs unchanged on deep sleep", int'(sigs), 10'b10_0000_0111);
        slp_deep_n = 1;
        wait_pst(2'd2, 20, "R4 suspend again");
    endtask

    task automatic t_run_up();
        int t0;
        clear_stamps();
        mv_sus = 13'd999; slp_susp_n = 1; tick(20);
        chk(!en_run, "R5 run held at 999 mV", int'(en_run), 0);
        mv_sus = 13'd1000;
        wait_sig(IIO, 1, STEP_C + 20, "R5 en_io rises");
        chk(rise_at[IIO] - rise_at[IRUN] >= STEP_C && rise_at[IIO] - rise_at[IRUN] <= STEP_C + 3,
            "R5 run-to-io delay", rise_at[IIO] - rise_at[IRUN], STEP_C);
        tick(10);
        chk(!sus_pg, "R5 sus_pg waits for pg_io", int'(sus_pg), 0);
        pg_io = 1;
        wait_sig(ISYS, 1, STEP_C + 20, "R5 sys_pwrok rises");
        chk(rise_at[ISPG] < rise_at[ICORE], "R5 sus_pg before core enable",
            rise_at[ISPG], rise_at[ICORE] - 1);
        chk(rise_at[ISYS] - rise_at[ICORE] >= STEP_C, "R5 core-to-sysok delay",
            rise_at[ISYS] - rise_at[ICORE], STEP_C);
        tick(20);
        chk(!host_pwrok, "R5 pwrok waits for core_ready", int'(host_pwrok), 0);
        core_ready = 1; t0 = cyc;
        wait_sig(IHOK, 1, STEP_C + 20, "R5 host_pwrok rises");
        chk(rise_at[IHOK] - t0 >= STEP_C && rise_at[IHOK] - t0 <= STEP_C + 8,
            "R5 ready-to-pwrok delay", rise_at[IHOK] - t0, STEP_C);
        tick(2);
        chk(pstate == 2'd3, "R5 run reached", int'(pstate), 3);
    endtask

    task automatic t_run_down();
        clear_stamps();
        slp_susp_n = 0;
        wait_pst(2'd2, 60, "R6 back to suspend");
        chk(fall_at[ISPG] >= 0 && fall_at[ISPG] < fall_at[IHOK] &&
            fall_at[IHOK] < fall_at[ISYS] && fall_at[ISYS] < fall_at[ICORE] &&
            fall_at[ICORE] < fall_at[IRUN], "R6 drop order",
            fall_at[IRUN], fall_at[ISPG] + 4);
        chk(fall_at[IIO] - fall_at[IRUN] >= GAP_C, "R6 io gap over 400 ns",
            fall_at[IIO] - fall_at[IRUN], GAP_C);
        chk(en_5v && en_3v3 && en_1v8 && host_rst_n, "R6 standby rails kept",
            int'(sigs), 10'b10_0000_0111);
    endtask

    task automatic t_force();
        slp_susp_n = 1;
        wait_pst(2'd3, 4 * STEP_C + 40, "R9 run again");
        clear_stamps();
        force_off = 1;
        wait_pst(2'd0, 80, "R9 forced shutdown to off");
        chk(fall_at[ISPG] >= 0 && fall_at[ISPG] < fall_at[IHOK] &&
            fall_at[ICORE] < fall_at[IRUN] && fall_at[IRUN] < fall_at[IIO] &&
            fall_at[IIO] < fall_at[IRST], "R9 run drop precedes standby",
            fall_at[IRST], fall_at[IIO] + 1);
        chk(fall_at[I1V8] - fall_at[IRST] >= GAP_C, "R7 rail gap over 400 ns",
            fall_at[I1V8] - fall_at[IRST], GAP_C);
        chk(fall_at[I1V8] < fall_at[I3V3] && fall_at[I3V3] < fall_at[I5V],
            "R7 rail drop order", fall_at[I5V], fall_at[I3V3] + 1);
        force_off = 0; tick(30);
        chk(!en_5v && pstate == 2'd0, "R8 no restart without new request edge",
            int'(en_5v), 0);
    endtask

    task automatic t_timeout_5v();
        pwr_req = 0; pg_5v = 0; pg_1v8 = 0; pg_1v05 = 0; pg_dram25 = 0;
        pg_dram12 = 0; pg_io = 0; core_ready = 0; slp_deep_n = 0;
        mv_3v3 = '0; mv_sus = '0; tick(10);
        clear_stamps();
        pwr_req = 1;
        wait_sig(I5V, 1, 20, "R8 en_5v rises");
        wait_sig(I5V, 0, TO_CYC + 60, "R8 timeout drops en_5v");
        chk(fall_at[I5V] - rise_at[I5V] >= TO_CYC && fall_at[I5V] - rise_at[I5V] <= TO_CYC + 40,
            "R8 timeout length", fall_at[I5V] - rise_at[I5V], TO_CYC);
        tick(2);
        chk(pstate == 2'd0, "R8 off after timeout", int'(pstate), 0);
        tick(40);
        chk(!en_5v, "R8 stays off while request held", int'(en_5v), 0);
    endtask

    task automatic t_window();
        pwr_req = 0; tick(10);
        pg_1v8 = 1; pg_1v05 = 1;
        pwr_req = 1;
        wait_sig(I5V, 1, 20, "R10 en_5v rises");
        tick(TO_CYC - 60); pg_5v = 1;
        wait_sig(I3V3, 1, 20, "R10 first wait no timeout");
        tick(TO_CYC - 60); mv_3v3 = 13'd3300;
        wait_pst(2'd1, RST_C + 40, "R10 second wait no timeout");
        clear_stamps();
        pwr_req = 0;
        wait_pst(2'd0, 80, "R9 request loss from standby");
        chk(fall_at[IRST] >= 0 && fall_at[IRST] < fall_at[I1V8] && !en_5v,
            "R9 standby teardown on request loss", fall_at[I1V8], fall_at[IRST] + GAP_C);
    endtask

    task automatic t_timeout_dram();
        pwr_req = 1;
        wait_pst(2'd1, RST_C + 60, "R8 standby for memory timeout");
        clear_stamps();
        slp_deep_n = 1;
        wait_pst(2'd0, TO_CYC + 80, "R8 memory wait timeout to off");
        chk(fall_at[IRST] >= 0 && fall_at[IRST] < fall_at[I1V8] &&
            fall_at[I3V3] < fall_at[I5V], "R8 memory timeout teardown order",
            fall_at[I5V], fall_at[I3V3] + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all R) actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_standby_up();
        t_suspend();
        t_run_up();
        t_run_down();
        t_force();
        t_timeout_5v();
        t_window();
        t_timeout_dram();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule